// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Band

This block is a timer for motor and power-stage control. A prescaler divides the system clock into counting ticks. A 16-bit up-counter steps from zero to a programmable period value and then wraps. Four channel pairs compare the counter against their own duty values. Each pair drives a high-side output and, when enabled, a low-side output that is the inverse of the high side. A programmable number of clock cycles is inserted around every transition, and both outputs stay inactive during that time.

Software programs the block through a write-only register port. It sees events through sticky flags and two interrupt lines: one for the period wrap and one for a duty match on any pair. Period and duty values are double-buffered. A write lands in a holding register, and the working copy takes it over only when the counter wraps, or at once while the timer is stopped. A running waveform therefore never shows a truncated or doubled pulse.

Register addresses are decoded from `wr_addr` and take data from `wr_data`:

- 0 is control. Bit 0 runs the timer. Bits 4:1 enable pairs 0..3. Bits 8:5 enable the low-side output of pairs 0..3. Bit 9 enables the period interrupt. Bit 10 enables the duty interrupt.
- 1 is the prescaler divisor P.
- 2 is the period T.
- 3 is the dead band D, counted in clock cycles.
- 4 clears flags when written with 1 bits. Bit 0 clears the wrap flag. Bit 1+i clears the duty flag of pair i.
- 8+i is the duty value of pair i.

Top module: `pwm_deadband_timer`

## Requirements
- R1: After reset, every PWM output, every flag and both interrupt lines are low.
- R2: While control bit 0 is set, the counter advances once every P+1 clock cycles. While control bit 0 is clear, the counter is held at zero.
- R3: The counter counts 0,1,..,T. On the tick where it is at T or above, it returns to 0 and sets the wrap flag. `irq_period` is the wrap flag ANDed with control bit 9.
- R4: The pair demand of pair i is high when the timer runs, control bit 1+i is set and the counter is below duty i. `pwm_hi[i]` is high exactly when this demand was high in each of the last D+1 cycles.
- R5: After every change of a pair's demand, both outputs of that pair stay low for D clock cycles before the new level appears.
- R6: When the demand of a pair lasts D cycles or fewer, neither output of that pair goes high for that pulse.
- R7: With control bit 5+i set, `pwm_lo[i]` is high exactly when pair i is enabled and its demand was low in each of the last D+1 cycles. With control bit 5+i clear, `pwm_lo[i]` stays low.
- R8: On the tick where the counter steps to a nonzero duty i, duty flag i is set. `irq_duty` is the OR of the duty flags ANDed with control bit 10.
- R9: Writing 1 to a flag's bit at address 4 clears that flag. A set in the same cycle wins over the clear.
- R10: A duty or period write made while the timer runs takes effect at the next wrap, not before.
- R11: A pair whose enable bit is clear holds `pwm_hi` low.
- R12: `pwm_hi[i]` and `pwm_lo[i]` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 4 | High-side output, one per pair |
| pwm_lo | output | 4 | Low-side (complementary) output, one per pair |
| ovf_flag | output | 1 | Sticky period-wrap flag |
| duty_flag | output | 4 | Sticky duty-match flag, one per pair |
| irq_period | output | 1 | Period interrupt |
| irq_duty | output | 1 | Duty-match interrupt |

## Verification
The bench sweeps dead bands of 0, 1 and 3 cycles, prescaler divisors of 1 and 3, and periods of 3 and 5. The four pairs carry duty values of 0 or 1, 2, T and T+1. These cover a pulse shorter than the dead band, a normal pulse, a pulse one tick short of full, and a demand that never drops. They separate a wrong comparison edge, a missing edge delay and a dead band applied on only one side. Alternate configurations disable one pair and the interrupt enables, so that gating errors show. A separate run rewrites a duty value in the middle of a period and clears the wrap flag twice. The first clear is free; the second lands on the wrap edge. This tells shadow timing and set-over-clear priority apart from plain flag behaviour.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // register addresses of the write port
  localparam int unsigned REG_CTRL      = 0;
  localparam int unsigned REG_PRESCALE  = 1;
  localparam int unsigned REG_PERIOD    = 2;
  localparam int unsigned REG_DEADTIME  = 3;
  localparam int unsigned REG_FLAGCLR   = 4;
  localparam int unsigned REG_DUTY_BASE = 8;

  // control word layout, derived from the number of pairs
  function automatic int unsigned ctrl_width(input int unsigned np);
    return 2 * np + 3;
  endfunction

  function automatic int unsigned pen_lsb(input int unsigned np);
    return (np > 0) ? 1 : 1;
  endfunction

  function automatic int unsigned cen_lsb(input int unsigned np);
    return np + 1;
  endfunction

  function automatic int unsigned iep_bit(input int unsigned np);
    return 2 * np + 1;
  endfunction

  function automatic int unsigned ied_bit(input int unsigned np);
    return 2 * np + 2;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] pc_q;

  // the divider has reached its limit (a limit lowered below the count also ends the cycle)
  function automatic logic f_at_limit(input logic [PSC_W-1:0] c, input logic [PSC_W-1:0] d);
    return c >= d;
  endfunction

  assign tick = run && f_at_limit(pc_q, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (!run || tick) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // R2: two ticks in a row only when the divisor is one
  p_tick_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || div == '0));

  // R2: a stopped timer produces no tick
  p_idle_no_tick_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_wr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_step,
  output logic             wrap_evt,
  output logic             shadow_ld
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_act_q;

  function automatic logic f_is_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c >= p;
  endfunction

  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return f_is_last(c, p) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt  = run && tick && f_is_last(cnt_q, period_act_q);
  assign shadow_ld = !run || wrap_evt;
  assign cnt_step  = f_next(cnt_q, period_act_q);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      period_act_q <= '0;
    end else begin
      if (!run) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_step;
      end
      if (shadow_ld) begin
        period_act_q <= period_wr;
      end
    end
  end

  // R3: the counter never runs past the working period
  p_in_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_act_q);

  // R3: a wrap returns the counter to zero
  p_wrap_zero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt_q == '0);

  // R2: the counter only moves on a tick
  p_move_on_tick_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

  // R10: the working period holds between wraps
  p_period_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_evt) |=> $stable(period_act_q));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             pair_en,
  input  logic             comp_en,
  input  logic             shadow_ld,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_step,
  input  logic [CNT_W-1:0] duty_wr,
  input  logic [DT_W-1:0]  dead,
  output logic             out_hi,
  output logic             out_lo,
  output logic             duty_hit
);

  logic [CNT_W-1:0] duty_act_q;
  logic             raw;
  logic             prev_q;
  logic [DT_W-1:0]  dcnt_q;
  logic [DT_W-1:0]  dt_ld_q;
  logic             settled;

  function automatic logic f_active(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  // pair demand before the dead band
  assign raw = run && pair_en && f_active(cnt, duty_act_q);

  // the counter is about to land on a nonzero duty value
  assign duty_hit = run && tick && (duty_act_q != '0) && (cnt_step == duty_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
    end else if (shadow_ld) begin
      duty_act_q <= duty_wr;
    end
  end

  // dead band: every demand edge restarts the quiet window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      dcnt_q  <= '0;
      dt_ld_q <= '0;
    end else if (raw != prev_q) begin
      prev_q  <= raw;
      dcnt_q  <= dead;
      dt_ld_q <= dead;
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign settled = (dcnt_q == '0);
  assign out_hi  = prev_q && settled;
  assign out_lo  = comp_en && pair_en && !prev_q && settled;

  // R12: the two sides of a pair never conduct together
  p_exclusive_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    !(out_hi && out_lo));

  // R5: with a nonzero dead band the low side never rises straight after the high side
  p_gap_lo_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_lo) && dt_ld_q != '0) |-> !$past(out_hi));

  // R5: the same gap in the other direction
  p_gap_hi_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_hi) && dt_ld_q != '0) |-> !$past(out_lo));

  // R10: the working duty holds between wraps
  p_duty_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_ld |=> $stable(duty_act_q));

endmodule

// File: rtl/pwm_deadband_timer.sv
module pwm_deadband_timer #(
  parameter int CNT_W   = 16,
  parameter int N_PAIRS = 4,
  parameter int PSC_W   = 8,
  parameter int DT_W    = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [N_PAIRS-1:0] pwm_hi,
  output logic [N_PAIRS-1:0] pwm_lo,
  output logic               ovf_flag,
  output logic [N_PAIRS-1:0] duty_flag,
  output logic               irq_period,
  output logic               irq_duty
);
  import pwm_dt_pkg::*;

  localparam int CTRL_W  = ctrl_width(N_PAIRS);
  localparam int PEN_LSB = pen_lsb(N_PAIRS);
  localparam int CEN_LSB = cen_lsb(N_PAIRS);
  localparam int IEP_B   = iep_bit(N_PAIRS);
  localparam int IED_B   = ied_bit(N_PAIRS);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [PSC_W-1:0]   psc_q;
  logic [CNT_W-1:0]   per_q;
  logic [DT_W-1:0]    dt_q;
  logic [CNT_W-1:0]   duty_q [N_PAIRS];

  logic               run;
  logic [N_PAIRS-1:0] pair_en;
  logic [N_PAIRS-1:0] comp_en;
  logic               tick;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_step;
  logic               wrap_evt;
  logic               shadow_ld;
  logic [N_PAIRS-1:0] duty_hit;
  logic               clr_hit;

  function automatic logic f_addr_is(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  assign run     = ctrl_q[0];
  assign pair_en = ctrl_q[PEN_LSB +: N_PAIRS];
  assign comp_en = ctrl_q[CEN_LSB +: N_PAIRS];
  assign clr_hit = wr_en && f_addr_is(wr_addr, REG_FLAGCLR);

  // ---------------- register file ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      per_q  <= '0;
      dt_q   <= '0;
    end else if (wr_en) begin
      if (f_addr_is(wr_addr, REG_CTRL))     ctrl_q <= wr_data[CTRL_W-1:0];
      if (f_addr_is(wr_addr, REG_PRESCALE)) psc_q  <= wr_data[PSC_W-1:0];
      if (f_addr_is(wr_addr, REG_PERIOD))   per_q  <= wr_data[CNT_W-1:0];
      if (f_addr_is(wr_addr, REG_DEADTIME)) dt_q   <= wr_data[DT_W-1:0];
    end
  end

  // ---------------- time base ----------------
  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (psc_q),
    .tick  (tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .period_wr (per_q),
    .cnt       (cnt),
    .cnt_step  (cnt_step),
    .wrap_evt  (wrap_evt),
    .shadow_ld (shadow_ld)
  );

  // ---------------- wrap flag ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (wrap_evt) begin
      ovf_flag <= 1'b1;
    end else if (clr_hit && wr_data[0]) begin
      ovf_flag <= 1'b0;
    end
  end

  // R3: a wrap always leaves the flag set
  p_ovf_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  // R9: a clear without a competing wrap drops the flag
  p_ovf_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && wr_data[0] && !wrap_evt) |=> !ovf_flag);

  // ---------------- channel pairs ----------------
  for (genvar gi = 0; gi < N_PAIRS; gi++) begin : g_pair

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q[gi] <= '0;
      end else if (wr_en && f_addr_is(wr_addr, REG_DUTY_BASE + gi)) begin
        duty_q[gi] <= wr_data[CNT_W-1:0];
      end
    end

    pwm_channel #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .pair_en   (pair_en[gi]),
      .comp_en   (comp_en[gi]),
      .shadow_ld (shadow_ld),
      .cnt       (cnt),
      .cnt_step  (cnt_step),
      .duty_wr   (duty_q[gi]),
      .dead      (dt_q),
      .out_hi    (pwm_hi[gi]),
      .out_lo    (pwm_lo[gi]),
      .duty_hit  (duty_hit[gi])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_flag[gi] <= 1'b0;
      end else if (duty_hit[gi]) begin
        duty_flag[gi] <= 1'b1;
      end else if (clr_hit && wr_data[gi+1]) begin
        duty_flag[gi] <= 1'b0;
      end
    end

    // R8: a duty match always leaves the pair's flag set
    p_duty_set_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      duty_hit[gi] |=> duty_flag[gi]);

    // R11: a disabled pair keeps its high side low
    p_disabled_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_en[gi] && $past(!pair_en[gi])) |-> !pwm_hi[gi]);
  end

  // ---------------- interrupts ----------------
  assign irq_period = ovf_flag && ctrl_q[IEP_B];
  assign irq_duty   = (|duty_flag) && ctrl_q[IED_B];

  // R3: the period line never fires without its flag
  p_irq_period_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> ovf_flag);

endmodule

// File: tb/pwm_deadband_timer_test.sv
module pwm_deadband_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NP-1:0] pwm_hi, pwm_lo, duty_flag;
  logic        ovf_flag, irq_period, irq_duty;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // configuration the expectations are computed from
  int cfg_psc, cfg_per, cfg_dt, sw_idx;
  int duty_a [NP];
  int duty_b [NP];
  logic [NP-1:0] pen, cen;
  bit ie_on;

  pwm_deadband_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .ovf_flag(ovf_flag), .duty_flag(duty_flag),
    .irq_period(irq_period), .irq_duty(irq_duty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // demand of pair p after the k-th edge since start (R2, R4, R10, R11)
  function automatic bit raw_at(int k, int p);
    int ticks, c, d;
    if (k < 0 || !pen[p]) return 0;
    ticks = k / (cfg_psc + 1);
    c = ticks % (cfg_per + 1);
    d = (k >= sw_idx) ? duty_b[p] : duty_a[p];
    return c < d;
  endfunction

  function automatic bit window_all(int m, int p, bit lvl);
    for (int k = m - 1 - cfg_dt; k <= m - 1; k++)
      if (raw_at(k, p) != lvl) return 0;
    return 1;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // full set of checks for the state after the m-th edge since start
  task automatic check_cycle(int m, bit exp_ovf);
    bit any_d = 0;
    for (int p = 0; p < NP; p++) begin
      int d = duty_a[p];
      bit ed = (d != 0) && (d <= cfg_per) && (m >= d * (cfg_psc + 1));
      any_d |= ed;
      chk("R4/R5/R6/R11", $sformatf("pwm_hi[%0d] m=%0d", p, m), int'(pwm_hi[p]), int'(window_all(m, p, 1'b1)));
      chk("R7/R5/R6", $sformatf("pwm_lo[%0d] m=%0d", p, m), int'(pwm_lo[p]),
          int'(cen[p] && pen[p] && window_all(m, p, 1'b0)));
      chk("R8", $sformatf("duty_flag[%0d] m=%0d", p, m), int'(duty_flag[p]), int'(ed));
      chk("R12", $sformatf("overlap[%0d] m=%0d", p, m), int'(pwm_hi[p] && pwm_lo[p]), 0);
    end
    chk("R3", $sformatf("ovf_flag m=%0d", m), int'(ovf_flag), int'(exp_ovf));
    chk("R3", $sformatf("irq_period m=%0d", m), int'(irq_period), int'(exp_ovf && ie_on));
    chk("R8", $sformatf("irq_duty m=%0d", m), int'(irq_duty), int'(any_d && ie_on));
  endtask

  task automatic start_cfg();
    reg_wr(0, 0);
    repeat (cfg_dt + 4) @(negedge clk);
    reg_wr(1, cfg_psc);
    reg_wr(2, cfg_per);
    reg_wr(3, cfg_dt);
    for (int p = 0; p < NP; p++) reg_wr(8 + p, duty_a[p]);
    reg_wr(4, 16'h001F);
    reg_wr(0, 1 | (int'(pen) << 1) | (int'(cen) << 5) | (int'(ie_on) << 9) | (int'(ie_on) << 10));
  endtask

  initial begin
    int dts [3] = '{0, 1, 3};
    int pss [2] = '{0, 2};
    int prs [2] = '{3, 5};
    int idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pwm_hi", int'(pwm_hi), 0);
    chk("R1", "pwm_lo", int'(pwm_lo), 0);
    chk("R1", "flags", int'({ovf_flag, duty_flag}), 0);
    chk("R1", "irqs", int'({irq_period, irq_duty}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: R2 R3 R4 R5 R6 R7 R8 R11 R12
    foreach (dts[a]) foreach (pss[b]) foreach (prs[c]) begin
      cfg_dt = dts[a]; cfg_psc = pss[b]; cfg_per = prs[c];
      duty_a[0] = (idx % 2 == 1) ? 0 : 1;
      duty_a[1] = 2;
      duty_a[2] = cfg_per;
      duty_a[3] = cfg_per + 1;
      for (int p = 0; p < NP; p++) duty_b[p] = duty_a[p];
      sw_idx = 1000000;
      pen = (idx % 2 == 1) ? 4'b1011 : 4'b1111;
      cen = 4'b0111;
      ie_on = (idx % 2 == 0);
      start_cfg();
      for (int m = 0; m <= 2 * (cfg_per + 1) * (cfg_psc + 1) + cfg_dt + 3; m++) begin
        if (m > 0) @(negedge clk);
        check_cycle(m, m >= (cfg_per + 1) * (cfg_psc + 1));
      end
      idx++;
    end

    // R10 duty shadow, R9 clear and set-over-clear
    cfg_dt = 0; cfg_psc = 0; cfg_per = 7;
    duty_a = '{2, 0, 0, 0};
    duty_b = '{5, 0, 0, 0};
    sw_idx = 16;
    pen = 4'b0001; cen = 4'b0001; ie_on = 1;
    start_cfg();
    for (int m = 0; m <= 40; m++) begin
      if (m > 0) @(negedge clk);
      check_cycle(m, (m >= 8) && !(m >= 21 && m < 24));
      wr_en = 1'b0;
      if (m == 9) begin wr_en = 1'b1; wr_addr = 4'd8; wr_data = 16'd5; end
      if (m == 20 || m == 31) begin wr_en = 1'b1; wr_addr = 4'd4; wr_data = 16'd1; end
    end
    wr_en = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule